// File: doc/BRIEF.md
# I2C Register-Access Slave Port

This block lets a bus master on a two-wire I2C bus write and read a bank of 8-bit control registers. SCL and SDA are brought into the system clock domain and checked for start, repeated start and stop conditions. The slave compares each address byte against its own 7-bit address and keeps a register pointer. It drives SDA low through an open-drain enable, and only to acknowledge a byte or to send read data. The register bank sits outside the block. The block presents the pointer as an address, issues a one-cycle write strobe together with the write data, and takes the read data back from a combinational return path.

A write transaction carries the device address with the direction bit at 0, then a pointer byte, then a data byte. A read first sets the pointer with the same two leading bytes. The master then issues a repeated start and resends the device address with the direction bit at 1, and the slave returns the addressed register MSB first. While reset is held, the block samples its strap and bus pins. If those pins select standalone operation, the block reports it, along with the clock master/slave choice that the external register bank should take as its defaults.

The register port has no back-pressure. The strobe is fire-and-forget, and the read data must be valid in the cycle that the pointer addresses it.

Top module: `i2cs_port`

## Requirements
- R1: The device address is 0x08 ORed with {strap_a1_i, strap_a0_i} in bits 1:0, using the strap levels captured during reset. An address byte (7 address bits, MSB first, then the direction bit) that matches is acknowledged by SDA held low during the ninth clock.
- R2: A write (start, address with direction 0, pointer byte, data byte, stop) acknowledges all three bytes. It raises reg_we_o exactly once, with reg_addr_o equal to the pointer byte and reg_wdata_o equal to the data byte.
- R3: After the pointer is set, a repeated start and an address byte with direction 1 make the slave send reg_rdata_i for that pointer, MSB first, on the following eight SCL clocks.
- R4: The slave begins driving SDA only while SCL is low.
- R5: A stop or start received before the data byte's eighth bit completes produces no write strobe, and the register bank is left unchanged.
- R6: During reset the block samples strap_a0_i, strap_a1_i, scl_i and sda_i. standalone_o is 1 when strap_a0_i, strap_a1_i and scl_i are all low. clk_master_o is 1 only in standalone mode with sda_i high. Both outputs hold their values until the next reset.
- R7: After a stop or a start condition, sda_oe_o is 0 in the next cycle.
- R8: reg_we_o is never high for two consecutive cycles.
- R9: After a non-matching address byte, the slave sends no acknowledge and drives nothing until the next start. A second byte sent after the mismatch is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; it must run well above the SCL rate |
| rst_n | input | 1 | Active-low synchronous reset; straps are sampled while it is low |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain) |
| strap_a0_i | input | 1 | Address strap, bit 0 |
| strap_a1_i | input | 1 | Address strap, bit 1 |
| reg_addr_o | output | 8 | Register pointer |
| reg_wdata_o | output | 8 | Write data |
| reg_we_o | output | 1 | One-cycle write strobe |
| reg_rdata_i | input | 8 | Data of register at reg_addr_o |
| standalone_o | output | 1 | Standalone mode selected at reset |
| clk_master_o | output | 1 | Standalone mode with ADC clocks as master |

## Verification
The bound checker covers the properties that hold on every cycle: the slave begins driving only while synchronized SCL is low, it releases after any start or stop, the write strobe is a single cycle that never fires while SCL is high, and the strap results stay stable after reset. Only the scenarios can show the rest. These are address matching under several strap settings, MSB-first read data after a repeated start, correct register contents after writes, the silence that follows a mismatched address, and the absence of writes after a transaction aborted mid-byte.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int BYTE_W = 8;
  localparam logic [6:0] DEV_BASE = 7'h08;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_A,
    ST_PTR,
    ST_ACK_P,
    ST_WDAT,
    ST_ACK_W,
    ST_RDAT,
    ST_MACK,
    ST_SKIP
  } eng_state_t;
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int WIDTH = 2,
  parameter int STAGES = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/i2cs_cond.sv
module i2cs_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  // data line moving while the clock stays high marks a bus condition
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2cs_strap.sv
module i2cs_strap (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       a0_i,
  input  logic       a1_i,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic [1:0] addr_lo_o,
  output logic       standalone_o,
  output logic       clk_master_o
);
  logic [1:0] a_cap;
  logic       scl_cap, sda_cap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_cap   <= {a1_i, a0_i};
      scl_cap <= scl_i;
      sda_cap <= sda_i;
    end
  end

  assign addr_lo_o    = a_cap;
  assign standalone_o = ~a_cap[0] & ~a_cap[1] & ~scl_cap;
  assign clk_master_o = standalone_o & sda_cap;
endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
  import i2cs_pkg::*;
#(
  parameter int PTR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              sda_s,
  input  logic [6:0]        dev_addr,
  input  logic [BYTE_W-1:0] rdata_i,
  output logic              sda_oe_o,
  output logic [PTR_W-1:0]  ptr_o,
  output logic [BYTE_W-1:0] wdata_o,
  output logic              we_o
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  eng_state_t        state;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] tx;
  logic              rw;
  logic              byte_done;

  assign byte_done = scl_fall && (cnt == FULL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      shreg    <= '0;
      tx       <= '0;
      rw       <= 1'b0;
      sda_oe_o <= 1'b0;
      ptr_o    <= '0;
      wdata_o  <= '0;
      we_o     <= 1'b0;
    end else begin
      we_o <= 1'b0;
      if (start_evt) begin
        state    <= ST_ADDR;
        cnt      <= '0;
        sda_oe_o <= 1'b0;
      end else if (stop_evt) begin
        state    <= ST_IDLE;
        cnt      <= '0;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR, ST_PTR, ST_WDAT: begin
            if (scl_rise && cnt != FULL) begin
              shreg <= {shreg[BYTE_W-2:0], sda_s};
              cnt   <= cnt + 1'b1;
            end else if (byte_done) begin
              cnt <= '0;
              if (state == ST_ADDR) begin
                if (shreg[BYTE_W-1:1] == dev_addr) begin
                  rw       <= shreg[0];
                  sda_oe_o <= 1'b1;
                  state    <= ST_ACK_A;
                end else begin
                  state <= ST_SKIP;
                end
              end else if (state == ST_PTR) begin
                ptr_o    <= PTR_W'(shreg);
                sda_oe_o <= 1'b1;
                state    <= ST_ACK_P;
              end else begin
                wdata_o  <= shreg;
                we_o     <= 1'b1;
                sda_oe_o <= 1'b1;
                state    <= ST_ACK_W;
              end
            end
          end
          ST_ACK_A: begin
            if (scl_fall) begin
              cnt <= '0;
              if (rw) begin
                sda_oe_o <= ~rdata_i[BYTE_W-1];
                tx       <= {rdata_i[BYTE_W-2:0], 1'b0};
                state    <= ST_RDAT;
              end else begin
                sda_oe_o <= 1'b0;
                state    <= ST_PTR;
              end
            end
          end
          ST_ACK_P: begin
            if (scl_fall) begin
              sda_oe_o <= 1'b0;
              state    <= ST_WDAT;
            end
          end
          ST_ACK_W: begin
            if (scl_fall) begin
              sda_oe_o <= 1'b0;
              state    <= ST_SKIP;
            end
          end
          ST_RDAT: begin
            if (scl_fall) begin
              if (cnt == LAST) begin
                sda_oe_o <= 1'b0;
                state    <= ST_MACK;
              end else begin
                sda_oe_o <= ~tx[BYTE_W-1];
                tx       <= {tx[BYTE_W-2:0], 1'b0};
                cnt      <= cnt + 1'b1;
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) state <= ST_SKIP;
          end
          default: begin
            sda_oe_o <= 1'b0;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/i2cs_port.sv
module i2cs_port
  import i2cs_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PTR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic              strap_a0_i,
  input  logic              strap_a1_i,
  output logic [PTR_W-1:0]  reg_addr_o,
  output logic [BYTE_W-1:0] reg_wdata_o,
  output logic              reg_we_o,
  input  logic [BYTE_W-1:0] reg_rdata_i,
  output logic              standalone_o,
  output logic              clk_master_o
);
  logic       scl_s, sda_s;
  logic       scl_rise, scl_fall, start_evt, stop_evt;
  logic [1:0] addr_lo;
  logic [6:0] dev_addr;

  i2cs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_i({scl_i, sda_i}), .q_o({scl_s, sda_s})
  );

  i2cs_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  i2cs_strap u_strap (
    .clk(clk), .rst_n(rst_n), .a0_i(strap_a0_i), .a1_i(strap_a1_i),
    .scl_i(scl_i), .sda_i(sda_i), .addr_lo_o(addr_lo),
    .standalone_o(standalone_o), .clk_master_o(clk_master_o)
  );

  assign dev_addr = DEV_BASE | {5'b0, addr_lo};

  i2cs_engine #(.PTR_W(PTR_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt), .sda_s(sda_s),
    .dev_addr(dev_addr), .rdata_i(reg_rdata_i), .sda_oe_o(sda_oe_o),
    .ptr_o(reg_addr_o), .wdata_o(reg_wdata_o), .we_o(reg_we_o)
  );
endmodule

// File: rtl/i2cs_port_chk.sv
module i2cs_port_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic sda_oe,
  input logic reg_we,
  input logic start_evt,
  input logic stop_evt,
  input logic standalone,
  input logic clk_master
);
  a_r4_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  a_r7_release_stop: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_oe);

  a_r7_release_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !sda_oe);

  a_r5_no_write_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !reg_we);

  a_r8_we_single: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  a_r2_we_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> !scl_s);

  a_r6_strap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(standalone) && $stable(clk_master));
endmodule

bind i2cs_port i2cs_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe_o),
  .reg_we(reg_we_o), .start_evt(start_evt), .stop_evt(stop_evt),
  .standalone(standalone_o), .clk_master(clk_master_o)
);

// File: tb/sim_i2cs_port.sv
`timescale 1ns/1ps
module sim_i2cs_port;
  localparam int Q = 25;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m_scl_low = 1'b0;
  logic       m_sda_low = 1'b0;
  logic       a0 = 1'b0, a1 = 1'b0;
  logic       scl, sda, sda_oe;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic       reg_we, standalone, clk_master;
  logic [7:0] mem [0:255];
  logic       mem_ready = 1'b0;
  int         we_pulses = 0, we_cycles = 0, r4_viol = 0;
  logic       we_q = 1'b0, oe_q = 1'b0;
  int         tests = 0, fails = 0;
  logic       done = 1'b0;

  always #5 clk = ~clk;

  assign scl = ~m_scl_low;
  assign sda = ~(m_sda_low | sda_oe);

  i2cs_port u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .sda_oe_o(sda_oe),
    .strap_a0_i(a0), .strap_a1_i(a1), .reg_addr_o(reg_addr),
    .reg_wdata_o(reg_wdata), .reg_we_o(reg_we), .reg_rdata_i(reg_rdata),
    .standalone_o(standalone), .clk_master_o(clk_master)
  );

  assign reg_rdata = mem[reg_addr];

  always @(posedge clk) begin
    if (!mem_ready) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h5A;
      mem_ready <= 1'b1;
    end else if (reg_we) begin
      mem[reg_addr] <= reg_wdata;
    end
  end

  always @(posedge clk) begin
    we_q <= reg_we;
    oe_q <= sda_oe;
    if (rst_n) begin
      if (reg_we) we_cycles++;
      if (reg_we && !we_q) we_pulses++;
      if (sda_oe && !oe_q && scl) r4_viol++;
    end
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(posedge clk); endtask

  task automatic bus_start();
    m_sda_low = 1'b0; wq();
    m_scl_low = 1'b0; wq();
    m_sda_low = 1'b1; wq();
    m_scl_low = 1'b1; wq();
  endtask

  task automatic bus_stop();
    m_sda_low = 1'b1; wq();
    m_scl_low = 1'b0; wq();
    m_sda_low = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda_low = ~b[i]; wq();
      m_scl_low = 1'b0; wq(); wq();
      m_scl_low = 1'b1;
    end
    m_sda_low = 1'b0; wq();
    m_scl_low = 1'b0; wq();
    ack = ~sda; wq();
    m_scl_low = 1'b1; wq();
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] b);
    m_sda_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      wq();
      m_scl_low = 1'b0; wq();
      b[i] = sda; wq();
      m_scl_low = 1'b1;
    end
    m_sda_low = ~nack; wq();
    m_scl_low = 1'b0; wq(); wq();
    m_scl_low = 1'b1; wq();
    m_sda_low = 1'b0;
  endtask

  task automatic do_reset(input logic s_a0, input logic s_a1,
                          input logic s_scl, input logic s_sda);
    rst_n = 1'b0; a0 = s_a0; a1 = s_a1;
    m_scl_low = ~s_scl; m_sda_low = ~s_sda;
    repeat (10) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    m_scl_low = 1'b0; wq();
    m_sda_low = 1'b0; wq(); wq();
  endtask

  task automatic t_straps();
    do_reset(1'b0, 1'b0, 1'b0, 1'b0);
    check(standalone == 1'b1, "R6 standalone slave", standalone, 1);
    check(clk_master == 1'b0, "R6 slave clocks", clk_master, 0);
    check(sda_oe == 1'b0 && reg_we == 1'b0, "R7 reset idle", sda_oe, 0);
    do_reset(1'b0, 1'b0, 1'b0, 1'b1);
    check(standalone == 1'b1, "R6 standalone master", standalone, 1);
    check(clk_master == 1'b1, "R6 master clocks", clk_master, 1);
    do_reset(1'b1, 1'b0, 1'b1, 1'b1);
    check(standalone == 1'b0, "R6 not standalone", standalone, 0);
    check(clk_master == 1'b0, "R6 no master", clk_master, 0);
  endtask

  task automatic wr(input logic [6:0] dev, input logic [7:0] p, input logic [7:0] d,
                    output logic [2:0] acks);
    bus_start();
    send_byte({dev, 1'b0}, acks[2]);
    send_byte(p, acks[1]);
    send_byte(d, acks[0]);
    bus_stop();
  endtask

  task automatic rd(input logic [6:0] dev, input logic [7:0] p,
                    output logic [7:0] d, output logic [2:0] acks);
    bus_start();
    send_byte({dev, 1'b0}, acks[2]);
    send_byte(p, acks[1]);
    bus_start();
    send_byte({dev, 1'b1}, acks[0]);
    recv_byte(1'b1, d);
    bus_stop();
  endtask

  task automatic t_write();
    logic [2:0] acks;
    int base = we_pulses;
    wr(7'h09, 8'h06, 8'hA5, acks);
    check(acks == 3'b111, "R1 R2 write acks", acks, 7);
    check(mem[6] == 8'hA5, "R2 write data", mem[6], 8'hA5);
    check(we_pulses == base + 1, "R2 one strobe", we_pulses - base, 1);
    check(sda_oe == 1'b0, "R7 released after stop", sda_oe, 0);
  endtask

  task automatic t_read();
    logic [2:0] acks;
    logic [7:0] d;
    rd(7'h09, 8'h06, d, acks);
    check(acks == 3'b111, "R3 read acks", acks, 7);
    check(d == 8'hA5, "R3 read written reg", d, 8'hA5);
    rd(7'h09, 8'h21, d, acks);
    check(d == 8'h7B, "R3 read MSB first", d, 8'h7B);
    wr(7'h09, 8'h10, 8'h3C, acks);
    rd(7'h09, 8'h10, d, acks);
    check(d == 8'h3C, "R3 read back 0x10", d, 8'h3C);
    check(sda_oe == 1'b0, "R7 released after read", sda_oe, 0);
  endtask

  task automatic t_mismatch();
    logic a1b, a2b;
    int base = we_pulses;
    bus_start();
    send_byte({7'h08, 1'b0}, a1b);
    send_byte(8'h06, a2b);
    bus_stop();
    check(a1b == 1'b0, "R1 wrong address not acked", a1b, 0);
    check(a2b == 1'b0, "R9 ignored after mismatch", a2b, 0);
    bus_start();
    send_byte({7'h0A, 1'b0}, a1b);
    bus_stop();
    check(a1b == 1'b0, "R9 address 0x0A ignored", a1b, 0);
    check(we_pulses == base, "R9 no write", we_pulses - base, 0);
  endtask

  task automatic t_abort();
    logic ack;
    logic [2:0] acks;
    logic [7:0] d;
    int base = we_pulses;
    bus_start();
    send_byte({7'h09, 1'b0}, ack);
    send_byte(8'h06, ack);
    for (int i = 0; i < 4; i++) begin
      m_sda_low = 1'b0; wq();
      m_scl_low = 1'b0; wq(); wq();
      m_scl_low = 1'b1; wq();
    end
    bus_stop();
    check(we_pulses == base, "R5 stop mid-byte no write", we_pulses - base, 0);
    check(mem[6] == 8'hA5, "R5 reg unchanged", mem[6], 8'hA5);
    bus_start();
    send_byte({7'h09, 1'b0}, ack);
    send_byte(8'h06, ack);
    m_sda_low = 1'b1; wq();
    m_scl_low = 1'b0; wq(); wq();
    m_scl_low = 1'b1; wq();
    bus_start();
    check(sda_oe == 1'b0, "R7 released after restart", sda_oe, 0);
    send_byte({7'h09, 1'b1}, ack);
    recv_byte(1'b1, d);
    bus_stop();
    check(we_pulses == base, "R5 restart mid-byte no write", we_pulses - base, 0);
    check(d == 8'hA5, "R5 pointer kept, reg unchanged", d, 8'hA5);
    rd(7'h09, 8'h06, d, acks);
    check(acks == 3'b111, "R5 recovers", acks, 7);
  endtask

  task automatic t_strap_addr();
    logic [2:0] acks;
    logic ack;
    do_reset(1'b1, 1'b1, 1'b1, 1'b1);
    wr(7'h0B, 8'h40, 8'hC3, acks);
    check(acks == 3'b111, "R1 address 0x0B acked", acks, 7);
    check(mem[8'h40] == 8'hC3, "R2 write at 0x40", mem[8'h40], 8'hC3);
    bus_start();
    send_byte({7'h09, 1'b0}, ack);
    bus_stop();
    check(ack == 1'b0, "R1 old address ignored", ack, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_straps();
    t_write();
    t_read();
    t_mismatch();
    t_abort();
    t_strap_addr();
    check(we_cycles == we_pulses, "R8 strobe single cycle", we_cycles, we_pulses);
    check(r4_viol == 0, "R4 drive starts with SCL low", r4_viol, 0);
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule